// File: doc/BRIEF.md
# Byte-Wide Memory Enable Decoder

This block sits between a processor core and a non-multiplexed byte-wide memory bus. For each access request it takes the 16-bit processor address, whether the access is a program fetch or a data access, and whether it writes. From these it produces the 15-bit bus address, four active-low memory chip enables, four active-low peripheral enables and an active-low read/write strobe. Accesses that the configuration does not map onto the byte-wide memory raise an expanded-bus request, and every byte-wide enable stays idle for them.

The configuration inputs are static in normal use. A memory-size select chooses between four 32 KB parts, one enable per part, and a single 128 KB part. In the 128 KB case two enable pins carry address bits 16 and 15. A partition mode makes one 64 KB space shared, with a movable program/data boundary counted in 2 KB granules. This mode is honoured only with 32 KB parts. A peripheral-select bit overlays a 64 KB data space of four 16 KB peripheral enables. A hold-off flag, which stands for reset or power failure, forces the whole bus idle.

The decoder is registered. A request presented before a clock edge shows up on the outputs after that edge, and the outputs then hold until the next edge.

Top module: `bwbus_decoder`

## Requirements
- R1: While rst_n is low and after it is released, with no request, every memory enable, every peripheral enable and bus_rw_n are high, xbus_req is low and bus_addr is zero.
- R2: If hold_off is high before a clock edge, then after that edge all enables and bus_rw_n are high and xbus_req is low, whatever request is present. bus_addr keeps its value.
- R3: Outputs change only at a clock edge and reflect the request sampled at that edge. An edge with req_valid low and hold_off low releases all enables and xbus_req and keeps bus_addr. A decoded request sets bus_addr to req_addr[14:0].
- R4: With ram_small=1 and part_mode=0 (fixed map), a fetch of 0000h–7FFFh asserts mem_ce_n[0] and a fetch of 8000h–FFFFh asserts mem_ce_n[1]. A data access of 0000h–7FFFh asserts mem_ce_n[2] and a data access of 8000h–FFFFh asserts mem_ce_n[3]. Exactly one memory enable is low.
- R5: With ram_small=0 the fixed map is always used and part_mode has no effect. Every mapped access drives mem_ce_n[0] low, mem_ce_n[1] carries physical bit 16 (1 for data, 0 for fetch), mem_ce_n[2] carries physical bit 15 (req_addr[15]), and mem_ce_n[3] stays high.
- R6: With ram_small=1 and part_mode=1, the boundary is part_bound×2048 bytes, and any part_bound above 32 counts as 32. A fetch below the boundary, or a data access of any address, asserts mem_ce_n[req_addr[15]] only.
- R7: In partition mode a fetch at or above the boundary drives xbus_req high and leaves all enables and bus_rw_n high.
- R8: A data write below the boundary in partition mode asserts its memory enable but keeps bus_rw_n high. A fetch never drives bus_rw_n low, even with req_write=1.
- R9: With periph_mode=1, a data access drives exactly one peripheral enable low, per_ce_n[req_addr[15:14]], keeps all memory enables high, and never raises xbus_req.
- R10: Fetches ignore periph_mode: they decode exactly as they would with periph_mode=0 and never assert a peripheral enable.
- R11: bus_rw_n goes low exactly for data writes that are not protected under R8 (mapped memory or peripheral), and only while an enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 16 | Processor address |
| req_fetch | input | 1 | 1 = program fetch, 0 = data access |
| req_write | input | 1 | 1 = data write |
| ram_small | input | 1 | 1 = four 32 KB parts, 0 = one 128 KB part |
| part_mode | input | 1 | 1 = shared space with movable boundary |
| part_bound | input | 6 | Boundary in 2 KB granules, clamped to 32 |
| periph_mode | input | 1 | 1 = data accesses go to the peripheral space |
| hold_off | input | 1 | Reset or power-fail: force the bus idle |
| bus_addr | output | 15 | Byte-wide bus address |
| mem_ce_n | output | 4 | Memory chip enables, or high address bits in 128 KB mode |
| per_ce_n | output | 4 | Peripheral enables, active low |
| bus_rw_n | output | 1 | Read/write strobe, low = write |
| xbus_req | output | 1 | Access belongs to the expanded bus |

## Verification
The hard cases are the addresses one byte either side of the partition boundary, a boundary of 0 or of 32 and above, and writes that land just under the boundary. Uniformly random addresses almost never hit these. The stimulus therefore draws a random boundary, including out-of-range codes, and then places about a third of the addresses within one byte of boundary×2048. Directed cases cover the extremes, the 128 KB mode with partition mode requested, and hold-off arriving together with a request.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam int PROC_AW = 16;   // processor address width
    localparam int BUS_AW  = 15;   // byte-wide bus address width
    localparam int N_MEMCE = 4;    // memory chip enables
    localparam int N_PERCE = 4;    // peripheral enables
    localparam int GRAN_LG = 11;   // partition granule = 2 KB
    localparam int BND_W   = 6;    // partition boundary field width

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_MEM    = 2'd1,
        ACC_PERIPH = 2'd2,
        ACC_XBUS   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [BUS_AW-1:0]  ba;
        logic [N_MEMCE-1:0] ce_n;
        logic [N_PERCE-1:0] pe_n;
        logic               rw_n;
        logic               xbus;
    } bus_state_t;

endpackage

// File: rtl/bwd_region.sv
module bwd_region
    import bwd_pkg::*;
#(
    parameter int AW     = PROC_AW,
    parameter int GLG    = GRAN_LG,
    parameter int BW     = BND_W
) (
    input  logic [AW-1:0] addr,
    input  logic          fetch,
    input  logic          small_ram,
    input  logic          part_mode,
    input  logic [BW-1:0] bound,
    input  logic          periph_mode,
    output acc_kind_e     kind,
    output logic [AW:0]   phys,
    output logic          wr_ok
);
    // number of granules in the whole processor space
    localparam logic [BW-1:0] MAX_GRAN = BW'(1 << (AW - GLG));

    logic          split_d;
    logic [BW-1:0] bnd_clamped_d;
    logic [AW:0]   bnd_byte_d;
    logic          below_d;

    // partition is only honoured with 32 KB parts
    assign split_d       = part_mode & small_ram;
    assign bnd_clamped_d = (bound > MAX_GRAN) ? MAX_GRAN : bound;
    assign bnd_byte_d    = {{(AW + 1 - BW){1'b0}}, bnd_clamped_d} << GLG;
    assign below_d       = ({1'b0, addr} < bnd_byte_d);

    always_comb begin
        kind  = ACC_MEM;
        phys  = {1'b0, addr};
        wr_ok = 1'b0;
        if (fetch) begin
            // program space is never written through the bus
            wr_ok = 1'b0;
            if (split_d && !below_d) begin
                kind = ACC_XBUS;
            end else begin
                kind = ACC_MEM;
                phys = {1'b0, addr};
            end
        end else if (periph_mode) begin
            kind  = ACC_PERIPH;
            phys  = {1'b0, addr};
            wr_ok = 1'b1;
        end else if (split_d) begin
            // shared space: data under the boundary is program, read only
            kind  = ACC_MEM;
            phys  = {1'b0, addr};
            wr_ok = !below_d;
        end else begin
            // fixed map: data lives in the upper 64 KB of physical space
            kind  = ACC_MEM;
            phys  = {1'b1, addr};
            wr_ok = 1'b1;
        end
    end

endmodule

// File: rtl/bwd_enables.sv
module bwd_enables
    import bwd_pkg::*;
#(
    parameter int AW  = PROC_AW,
    parameter int NCE = N_MEMCE,
    parameter int NPE = N_PERCE
) (
    input  acc_kind_e        kind,
    input  logic [AW:0]      phys,
    input  logic             small_ram,
    output logic [NCE-1:0]   ce_n,
    output logic [NPE-1:0]   pe_n
);
    localparam int CSEL_W = $clog2(NCE);
    localparam int PSEL_W = $clog2(NPE);

    logic [NCE-1:0]    ce_small;
    logic [NCE-1:0]    ce_large;
    logic [CSEL_W-1:0] csel;
    logic [PSEL_W-1:0] psel;
    logic              is_mem;
    logic              is_per;

    assign csel   = phys[AW -: CSEL_W];
    assign psel   = phys[AW-1 -: PSEL_W];
    assign is_mem = (kind == ACC_MEM);
    assign is_per = (kind == ACC_PERIPH);

    // one enable per 32 KB part
    for (genvar gi = 0; gi < NCE; gi++) begin : g_small
        assign ce_small[gi] = !(is_mem && (csel == CSEL_W'(gi)));
    end

    // single large part: enable 0 selects, 1 and 2 become address bits
    if (NCE >= 3) begin : g_large
        always_comb begin
            ce_large = '1;
            if (is_mem) begin
                ce_large[0] = 1'b0;
                ce_large[1] = phys[AW];
                ce_large[2] = phys[AW-1];
            end
        end
    end else begin : g_large_none
        assign ce_large = is_mem ? {{(NCE-1){1'b1}}, 1'b0} : '1;
    end

    assign ce_n = small_ram ? ce_small : ce_large;

    for (genvar gp = 0; gp < NPE; gp++) begin : g_per
        assign pe_n[gp] = !(is_per && (psel == PSEL_W'(gp)));
    end

endmodule

// File: rtl/bwbus_decoder.sv
module bwbus_decoder
    import bwd_pkg::*;
#(
    parameter int AW  = PROC_AW,
    parameter int BAW = BUS_AW,
    parameter int NCE = N_MEMCE,
    parameter int NPE = N_PERCE,
    parameter int GLG = GRAN_LG,
    parameter int BW  = BND_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic           req_fetch,
    input  logic           req_write,
    input  logic           ram_small,
    input  logic           part_mode,
    input  logic [BW-1:0]  part_bound,
    input  logic           periph_mode,
    input  logic           hold_off,
    output logic [BAW-1:0] bus_addr,
    output logic [NCE-1:0] mem_ce_n,
    output logic [NPE-1:0] per_ce_n,
    output logic           bus_rw_n,
    output logic           xbus_req
);
    acc_kind_e      kind_d;
    logic [AW:0]    phys_d;
    logic           wr_ok_d;
    logic [NCE-1:0] ce_n_d;
    logic [NPE-1:0] pe_n_d;
    bus_state_t     state_d;
    bus_state_t     state_q;

    bwd_region #(
        .AW (AW),
        .GLG(GLG),
        .BW (BW)
    ) u_region (
        .addr       (req_addr),
        .fetch      (req_fetch),
        .small_ram  (ram_small),
        .part_mode  (part_mode),
        .bound      (part_bound),
        .periph_mode(periph_mode),
        .kind       (kind_d),
        .phys       (phys_d),
        .wr_ok      (wr_ok_d)
    );

    bwd_enables #(
        .AW (AW),
        .NCE(NCE),
        .NPE(NPE)
    ) u_enables (
        .kind     (kind_d),
        .phys     (phys_d),
        .small_ram(ram_small),
        .ce_n     (ce_n_d),
        .pe_n     (pe_n_d)
    );

    always_comb begin
        state_d      = state_q;
        state_d.ce_n = '1;
        state_d.pe_n = '1;
        state_d.rw_n = 1'b1;
        state_d.xbus = 1'b0;
        if (!hold_off && req_valid) begin
            state_d.ba   = req_addr[BAW-1:0];
            state_d.ce_n = ce_n_d;
            state_d.pe_n = pe_n_d;
            state_d.xbus = (kind_d == ACC_XBUS);
            state_d.rw_n = !(req_write && !req_fetch && wr_ok_d &&
                             (kind_d != ACC_XBUS));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.ce_n <= '1;
            state_q.pe_n <= '1;
            state_q.rw_n <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_addr = state_q.ba;
    assign mem_ce_n = state_q.ce_n;
    assign per_ce_n = state_q.pe_n;
    assign bus_rw_n = state_q.rw_n;
    assign xbus_req = state_q.xbus;

    // ---------------- assertions ----------------
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_off |=> (&mem_ce_n && &per_ce_n && bus_rw_n && !xbus_req));

    p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_off && !req_valid) |=> (&mem_ce_n && &per_ce_n && !xbus_req
                                        && $stable(bus_addr)));

    p_large_top_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_off && req_valid && !ram_small) |=> mem_ce_n[NCE-1]);

    p_xbus_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_req |-> (&mem_ce_n && &per_ce_n && bus_rw_n));

    p_fetch_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch) |=> bus_rw_n);

    p_pe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~per_ce_n));

    p_pe_excludes_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(&per_ce_n) |-> (&mem_ce_n && !xbus_req));

    p_fetch_no_pe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch) |=> &per_ce_n);

    p_write_has_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rw_n |-> (!(&mem_ce_n) || !(&per_ce_n)));

endmodule

// File: tb/sim_bwbus_decoder.sv
module sim_bwbus_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_fetch = 1'b0;
    logic        req_write = 1'b0;
    logic        ram_small = 1'b1;
    logic        part_mode = 1'b0;
    logic [5:0]  part_bound = '0;
    logic        periph_mode = 1'b0;
    logic        hold_off = 1'b0;
    logic [14:0] bus_addr;
    logic [3:0]  mem_ce_n;
    logic [3:0]  per_ce_n;
    logic        bus_rw_n;
    logic        xbus_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [14:0] exp_ba = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bwbus_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_fetch(req_fetch), .req_write(req_write), .ram_small(ram_small),
        .part_mode(part_mode), .part_bound(part_bound), .periph_mode(periph_mode),
        .hold_off(hold_off), .bus_addr(bus_addr), .mem_ce_n(mem_ce_n),
        .per_ce_n(per_ce_n), .bus_rw_n(bus_rw_n), .xbus_req(xbus_req)
    );

    // expected bus word: {ba, ce_n, pe_n, rw_n, xbus}
    function automatic logic [24:0] model(input logic [14:0] prev_ba);
        logic [3:0] ce;
        logic [3:0] pe;
        logic       rw;
        logic       xb;
        int         bnd;
        int         a;
        int         blk;
        bit         mem;
        bit         split;
        ce = 4'hF; pe = 4'hF; rw = 1'b1; xb = 1'b0; mem = 0; blk = 0;
        if (hold_off || !req_valid) return {prev_ba, ce, pe, rw, xb};
        a     = int'(req_addr);
        bnd   = (int'(part_bound) > 32 ? 32 : int'(part_bound)) * 2048;
        split = ram_small && part_mode;
        if (req_fetch) begin
            if (split && a >= bnd) xb = 1'b1;
            else begin mem = 1; blk = a / 32768; end
        end else if (periph_mode) begin
            pe[a / 16384] = 1'b0;
            rw = !req_write;
        end else if (split) begin
            mem = 1; blk = a / 32768;
            rw = !(req_write && a >= bnd);
        end else begin
            mem = 1; blk = 2 + a / 32768;
            rw = !req_write;
        end
        if (mem) begin
            if (ram_small) ce[blk] = 1'b0;
            else begin
                ce[0] = 1'b0;
                ce[1] = (blk >= 2);
                ce[2] = (blk % 2 == 1);
                ce[3] = 1'b1;
            end
        end
        return {req_addr[14:0], ce, pe, rw, xb};
    endfunction

    function automatic string tag_now();
        int bnd;
        bnd = (int'(part_bound) > 32 ? 32 : int'(part_bound)) * 2048;
        if (hold_off) return "R2";
        if (!req_valid) return "R3";
        if (!ram_small) return "R5";
        if (req_fetch && periph_mode) return "R10";
        if (req_fetch && part_mode && int'(req_addr) >= bnd) return "R7";
        if (!req_fetch && periph_mode) return "R9";
        if (!req_fetch && part_mode && req_write && int'(req_addr) < bnd) return "R8";
        if (part_mode) return "R6";
        if (req_write) return "R11";
        return "R4";
    endfunction

    task automatic check(input logic [24:0] expv, input string tag);
        logic [24:0] act;
        act = {bus_addr, mem_ce_n, per_ce_n, bus_rw_n, xbus_req};
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual ba=%h ce=%b pe=%b rw=%b xb=%b expected ba=%h ce=%b pe=%b rw=%b xb=%b",
                     tag, act[24:10], act[9:6], act[5:2], act[1], act[0],
                     expv[24:10], expv[9:6], expv[5:2], expv[1], expv[0]);
        end
    endtask

    // inputs are set at a negedge; result checked at the next negedge
    task automatic step(input string tag);
        logic [24:0] e;
        string       t;
        e = model(exp_ba);
        t = (tag == "") ? tag_now() : tag;
        @(posedge clk);
        @(negedge clk);
        check(e, t);
        exp_ba = e[24:10];
    endtask

    task automatic req(input logic [15:0] a, input logic f, input logic w,
                       input string tag);
        req_valid = 1'b1; req_addr = a; req_fetch = f; req_write = w;
        step(tag);
    endtask

    task automatic cfg(input logic sm, input logic pm, input logic [5:0] b,
                       input logic pe);
        ram_small = sm; part_mode = pm; part_bound = b; periph_mode = pe;
    endtask

    initial begin
        void'($urandom(32'h0bad_5eed));
        @(negedge clk);
        check({15'h0, 4'hF, 4'hF, 1'b1, 1'b0}, "R1 in reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({15'h0, 4'hF, 4'hF, 1'b1, 1'b0}, "R1 after reset");

        // R4 fixed map, 32 KB parts
        cfg(1, 0, 6'd8, 0);
        req(16'h7FFF, 1, 0, "R4 fetch low");
        req(16'h8000, 1, 0, "R4 fetch high");
        req(16'h1234, 0, 1, "R4 R11 data write low");
        req(16'hC001, 0, 0, "R4 data read high");
        // R3 idle keeps address
        req_valid = 1'b0; step("R3 idle");
        // R5 large part, partition request ignored
        cfg(0, 1, 6'd4, 0);
        req(16'h9000, 1, 0, "R5 fetch");
        req(16'h0100, 0, 1, "R5 data write");
        req(16'hF000, 0, 0, "R5 data high");
        // R6/R7/R8 partition edges
        cfg(1, 1, 6'd5, 0);
        req(16'h27FF, 1, 0, "R6 fetch below bound");
        req(16'h2800, 1, 0, "R7 fetch at bound");
        req(16'h27FF, 0, 1, "R8 protected write");
        req(16'h2800, 0, 1, "R11 write at bound");
        req(16'h0000, 1, 1, "R8 fetch with write");
        cfg(1, 1, 6'd0, 0);
        req(16'h0000, 1, 0, "R7 zero bound");
        cfg(1, 1, 6'd45, 0);
        req(16'hFFFF, 1, 0, "R6 clamped bound fetch");
        req(16'hFFFF, 0, 1, "R8 clamped bound write");
        // R9/R10 peripheral overlay
        cfg(1, 0, 6'd0, 1);
        req(16'h3FFF, 0, 1, "R9 pe0 write");
        req(16'h4000, 0, 0, "R9 pe1");
        req(16'hBFFF, 0, 0, "R9 pe2");
        req(16'hC000, 0, 1, "R9 pe3");
        req(16'hC000, 1, 0, "R10 fetch ignores periph");
        // R2 hold-off with request present
        hold_off = 1'b1;
        req(16'h5555, 0, 1, "R2 hold with request");
        hold_off = 1'b0;

        for (int i = 0; i < 3000; i++) begin
            logic [5:0] b;
            int         a;
            b = 6'($urandom_range(0, 40));
            cfg(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), b,
                1'($urandom_range(0, 4) == 0));
            hold_off  = ($urandom_range(0, 19) == 0);
            req_valid = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 2) == 0) begin
                a = (int'(b) > 32 ? 32 : int'(b)) * 2048 + int'($urandom_range(0, 2)) - 1;
                if (a < 0) a = 0;
                if (a > 65535) a = 65535;
            end else begin
                a = int'($urandom_range(0, 65535));
            end
            req_addr  = 16'(a);
            req_fetch = 1'($urandom_range(0, 1));
            req_write = 1'($urandom_range(0, 1));
            step("");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule